// File: doc/BRIEF.md
# SPI Buffer and Interrupt Unit

This unit sits between a memory-mapped register port and an SPI serial engine. Host software pushes transmit words and pops receive words through a single data register. The serial engine takes words from the transmit queue and delivers received words into the receive queue, each through a one-cycle handshake. Each direction holds sixteen words of up to 32 bits. A single write to a flush register empties both queues.

A threshold register holds two 4-bit trigger levels, one for each direction. These levels decide when the "receive full" and "transmit empty" conditions are raised. A 16-bit status register combines live level flags with sticky error and completion flags. The sticky flags are cleared by writing a mask, and a mask of 0xFD80 clears all of them at once. Five interrupt lines come out of the unit. Idle and error are level outputs. Communication end, receive and transmit are single-cycle pulses. The receive pulse is gated by bit 17 of the control register.

Register word addresses on `reg_addr` are:
- 0: data
- 1: control
- 2: thresholds
- 3: status (read)
- 4: status clear (write)
- 5: flush (write)
- 6: fill levels (read)

Control bits are:
- bit 0: run (lets the engine pop)
- bit 16: transmit interrupt enable
- bit 17: receive interrupt enable
- bit 18: error interrupt enable
- bit 19: idle interrupt enable
- bit 20: end interrupt enable

Top module: `spi_bufirq_unit`

## Requirements
- R1: The transmit queue holds 16 words. A data-register write to a full queue is dropped and sets sticky status bit 11. The fill levels read at address 6, with the transmit level in bits 4:0 and the receive level in bits 20:16.
- R2: A write to address 0 pushes the transmit queue. The engine sees the oldest word on `eng_tx_data`, and `eng_tx_valid` is high only while the queue is non-empty and control bit 0 is set. Each `eng_tx_pop` advances to the next word in write order.
- R3: A read of address 0 returns and pops the oldest received word. A read while the receive queue is empty returns 0 and sets sticky status bit 8.
- R4: The threshold register (address 2) stores the transmit trigger in bits 11:8 and the receive trigger in bits 3:0, and reads both back.
- R5: Status bit 15 is 1 exactly when the receive level is greater than the receive trigger, so a trigger of 0 raises it after one word.
- R6: Status bit 7 is 1 exactly when the transmit level is less than or equal to the transmit trigger.
- R7: Writing a mask to address 4 clears the sticky flags (bits 8, 10, 11 and 12) whose mask bits are 1. A mask of 0xFD80 clears them all. Level flags (bits 15, 14 and 7) are unaffected, and flags whose mask bit is 0 are kept.
- R8: Writing a value with bit 0 set to address 5 empties both queues at that clock edge.
- R9: `irq_rx` is a one-cycle pulse when status bit 15 rises, and only while control bit 17 is set.
- R10: `irq_tx` is a one-cycle pulse when status bit 7 rises, and only while control bit 16 is set.
- R11: An `eng_done` sampled while the transmit queue is empty sets sticky status bit 12. If control bit 20 is set, it also gives a one-cycle `irq_end` pulse in the following cycle. No pulse occurs while the queue still holds words.
- R12: `irq_idle` is high while control bit 19 is set, the transmit queue is empty and `eng_busy` is low; status bit 14 shows the same idle condition without the enable. `irq_err` is high while control bit 18 is set and any of status bits 8, 10 or 11 is set.
- R13: An engine push to a full receive queue is dropped and sets sticky status bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| eng_tx_pop | input | 1 | Engine takes the current transmit word |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_busy | input | 1 | Engine is shifting a frame |
| eng_done | input | 1 | Engine finished shifting a frame |
| irq_idle | output | 1 | Idle interrupt, level |
| irq_err | output | 1 | Error interrupt, level |
| irq_end | output | 1 | Communication end interrupt, pulse |
| irq_rx | output | 1 | Receive full interrupt, pulse |
| irq_tx | output | 1 | Transmit empty interrupt, pulse |

## Verification
Queue contents, fill levels, thresholds and sticky flags change at the clock edge that samples the request. The bench reads them in the next cycle through the combinational read port. The receive and transmit pulses are decoded from registered levels, so each is high for exactly the one cycle after the edge that moved the level; the bench samples them at the following falling edge and again one cycle later to see them drop. The end pulse is registered, so it is high in the cycle after the edge that sampled `eng_done`. The idle and error levels follow the same edge, and the bench checks them after any stimulus has settled.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

  typedef enum logic [3:0] {
    A_DATA    = 4'd0,
    A_CTRL    = 4'd1,
    A_THRESH  = 4'd2,
    A_STAT    = 4'd3,
    A_STATCLR = 4'd4,
    A_FLUSH   = 4'd5,
    A_LEVEL   = 4'd6
  } sbi_addr_e;

  // control bit positions
  localparam int CB_RUN    = 0;
  localparam int CB_TXIE   = 16;
  localparam int CB_RXIE   = 17;
  localparam int CB_ERRIE  = 18;
  localparam int CB_IDLEIE = 19;
  localparam int CB_ENDIE  = 20;
  localparam logic [31:0] CTRL_MASK = 32'h001F_0001;

  // status bit positions
  localparam int SB_TXE   = 7;
  localparam int SB_UDF   = 8;
  localparam int SB_RXOVF = 10;
  localparam int SB_TXOVF = 11;
  localparam int SB_END   = 12;
  localparam int SB_IDLE  = 14;
  localparam int SB_RXF   = 15;
  localparam logic [15:0] STICKY_MASK = 16'h1D00;
  localparam logic [15:0] ERR_MASK    = 16'h0D00;

  // threshold field positions
  localparam int TH_TX_LSB = 8;
  localparam int TH_RX_LSB = 0;

  // receive side: enough words gathered
  function automatic logic lvl_above(input logic [7:0] lvl, input logic [7:0] trig);
    return lvl > trig;
  endfunction

  // transmit side: room opened up
  function automatic logic lvl_at_or_below(input logic [7:0] lvl, input logic [7:0] trig);
    return lvl <= trig;
  endfunction

endpackage

// File: rtl/sbi_fifo.sv
module sbi_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [DW-1:0]               wdata,
  input  logic                        pop,
  output logic [DW-1:0]               head,
  output logic [$clog2(DEPTH):0]      level,
  output logic                        empty,
  output logic                        push_drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          full, push_ok, pop_ok;

  assign full      = (cnt == LW'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_ok   = push & ~full & ~clr;
  assign pop_ok    = pop & ~empty & ~clr;
  assign push_drop = push & full & ~clr;
  assign head      = mem[rd_ptr];
  assign level     = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/sbi_regs.sv
module sbi_regs
  import sbi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LW     = 5,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [LW-1:0]     tx_level,
  input  logic [LW-1:0]     rx_level,
  input  logic [DATA_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic              set_udf,
  input  logic              set_rxovf,
  input  logic              set_txovf,
  input  logic              set_end,
  input  logic              flag_rxf,
  input  logic              flag_txe,
  input  logic              flag_idle,
  output logic              run,
  output logic              tx_ie,
  output logic              rx_ie,
  output logic              err_ie,
  output logic              idle_ie,
  output logic              end_ie,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [TRIG_W-1:0] rx_trig,
  output logic              err_any,
  output logic [15:0]       status,
  output logic [31:0]       rdata
);
  logic [31:0] ctrl_q;
  logic [15:0] stick_q, set_v, clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tx_trig <= '0;
      rx_trig <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) ctrl_q <= wdata & CTRL_MASK;
      if (addr == A_THRESH) begin
        tx_trig <= wdata[TH_TX_LSB +: TRIG_W];
        rx_trig <= wdata[TH_RX_LSB +: TRIG_W];
      end
    end
  end

  always_comb begin
    set_v            = '0;
    set_v[SB_UDF]    = set_udf;
    set_v[SB_RXOVF]  = set_rxovf;
    set_v[SB_TXOVF]  = set_txovf;
    set_v[SB_END]    = set_end;
    clr_v = (wr && addr == A_STATCLR) ? (wdata[15:0] & STICKY_MASK) : '0;
  end

  // a new event in the same cycle as a clear keeps its flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stick_q <= '0;
    else        stick_q <= (stick_q & ~clr_v) | set_v;
  end

  always_comb begin
    status          = stick_q;
    status[SB_RXF]  = flag_rxf;
    status[SB_IDLE] = flag_idle;
    status[SB_TXE]  = flag_txe;
  end

  assign err_any = |(stick_q & ERR_MASK);
  assign run     = ctrl_q[CB_RUN];
  assign tx_ie   = ctrl_q[CB_TXIE];
  assign rx_ie   = ctrl_q[CB_RXIE];
  assign err_ie  = ctrl_q[CB_ERRIE];
  assign idle_ie = ctrl_q[CB_IDLEIE];
  assign end_ie  = ctrl_q[CB_ENDIE];

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA:   if (!rx_empty) rdata[DATA_W-1:0] = rx_head;
      A_CTRL:   rdata = ctrl_q;
      A_THRESH: begin
        rdata[TH_TX_LSB +: TRIG_W] = tx_trig;
        rdata[TH_RX_LSB +: TRIG_W] = rx_trig;
      end
      A_STAT:   rdata[15:0] = status;
      A_LEVEL:  begin
        rdata[LW-1:0]    = tx_level;
        rdata[16 +: LW]  = rx_level;
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sbi_irq.sv
module sbi_irq
  import sbi_pkg::*;
#(
  parameter int LW     = 5,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     tx_level,
  input  logic [LW-1:0]     rx_level,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic              tx_ie,
  input  logic              rx_ie,
  input  logic              err_ie,
  input  logic              idle_ie,
  input  logic              end_ie,
  input  logic              err_any,
  input  logic              end_evt,
  input  logic              idle_now,
  output logic              rxf_cond,
  output logic              txe_cond,
  output logic              irq_idle,
  output logic              irq_err,
  output logic              irq_end,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic rxf_prev, txe_prev, end_q;

  assign rxf_cond = lvl_above(8'(rx_level), 8'(rx_trig));
  assign txe_cond = lvl_at_or_below(8'(tx_level), 8'(tx_trig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_prev <= 1'b0;
      txe_prev <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      rxf_prev <= rxf_cond;
      txe_prev <= txe_cond;
      end_q    <= end_evt & end_ie;
    end
  end

  assign irq_rx   = rxf_cond & ~rxf_prev & rx_ie;
  assign irq_tx   = txe_cond & ~txe_prev & tx_ie;
  assign irq_end  = end_q;
  assign irq_idle = idle_now & idle_ie;
  assign irq_err  = err_any & err_ie;
endmodule

// File: rtl/spi_bufirq_unit.sv
module spi_bufirq_unit
  import sbi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_tx_pop,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              irq_idle,
  output logic              irq_err,
  output logic              irq_end,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [LW-1:0]     tx_level, rx_level;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic              tx_empty, rx_empty, tx_drop, rx_drop;
  logic              host_push, host_pop, fifo_clr, udf_evt, end_evt, idle_now;
  logic              run, tx_ie, rx_ie, err_ie, idle_ie, end_ie, err_any;
  logic              rxf_cond, txe_cond, eng_pop_req;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic [15:0]       status;

  // named internal events
  assign host_push   = reg_wr & (reg_addr == A_DATA);
  assign host_pop    = reg_rd & (reg_addr == A_DATA);
  assign fifo_clr    = reg_wr & (reg_addr == A_FLUSH) & reg_wdata[0];
  assign udf_evt     = host_pop & rx_empty & ~fifo_clr;
  assign end_evt     = eng_done & tx_empty;
  assign idle_now    = tx_empty & ~eng_busy;
  assign eng_pop_req = eng_tx_pop & run;

  sbi_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(host_push), .wdata(reg_wdata[DATA_W-1:0]),
    .pop(eng_pop_req), .head(tx_head), .level(tx_level),
    .empty(tx_empty), .push_drop(tx_drop)
  );

  sbi_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(host_pop), .head(rx_head), .level(rx_level),
    .empty(rx_empty), .push_drop(rx_drop)
  );

  sbi_regs #(.DATA_W(DATA_W), .LW(LW), .TRIG_W(TRIG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tx_level(tx_level), .rx_level(rx_level), .rx_head(rx_head), .rx_empty(rx_empty),
    .set_udf(udf_evt), .set_rxovf(rx_drop), .set_txovf(tx_drop), .set_end(end_evt),
    .flag_rxf(rxf_cond), .flag_txe(txe_cond), .flag_idle(idle_now),
    .run(run), .tx_ie(tx_ie), .rx_ie(rx_ie), .err_ie(err_ie),
    .idle_ie(idle_ie), .end_ie(end_ie),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .err_any(err_any),
    .status(status), .rdata(reg_rdata)
  );

  sbi_irq #(.LW(LW), .TRIG_W(TRIG_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .err_ie(err_ie), .idle_ie(idle_ie), .end_ie(end_ie),
    .err_any(err_any), .end_evt(end_evt), .idle_now(idle_now),
    .rxf_cond(rxf_cond), .txe_cond(txe_cond),
    .irq_idle(irq_idle), .irq_err(irq_err), .irq_end(irq_end),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  assign eng_tx_valid = run & ~tx_empty;
  assign eng_tx_data  = tx_empty ? '0 : tx_head;
endmodule

// File: rtl/sbi_checker.sv
module sbi_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          fifo_clr,
  input logic          udf_evt,
  input logic          end_evt,
  input logic          tx_drop,
  input logic [15:0]   status,
  input logic          irq_rx,
  input logic          irq_tx
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R1

  AST_TXOVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> status[11]); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (tx_level == '0) && (rx_level == '0)); // R8

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> status[8]); // R3

  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> status[12]); // R11

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx); // R9

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx); // R10
endmodule

bind spi_bufirq_unit sbi_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
  .fifo_clr(fifo_clr), .udf_evt(udf_evt), .end_evt(end_evt), .tx_drop(tx_drop),
  .status(status), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/spi_bufirq_unit_tb.sv
module spi_bufirq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_tx_pop = 0, eng_rx_push = 0, eng_busy = 0, eng_done = 0;
  logic        eng_tx_valid;
  logic [31:0] eng_tx_data;
  logic [31:0] eng_rx_data = '0;
  logic        irq_idle, irq_err, irq_end, irq_rx, irq_tx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_bufirq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .eng_done(eng_done),
    .irq_idle(irq_idle), .irq_err(irq_err), .irq_end(irq_end), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // {tx_trig, rx_trig, words, expect tx-empty, expect rx-full}
  localparam logic [14:0] VEC [8] = '{
    {4'd0,  4'd0,  5'd0,  1'b1, 1'b0},
    {4'd0,  4'd0,  5'd1,  1'b0, 1'b1},
    {4'd3,  4'd3,  5'd3,  1'b1, 1'b0},
    {4'd3,  4'd3,  5'd4,  1'b0, 1'b1},
    {4'd15, 4'd15, 5'd15, 1'b1, 1'b0},
    {4'd15, 4'd15, 5'd16, 1'b0, 1'b1},
    {4'd5,  4'd2,  5'd2,  1'b1, 1'b0},
    {4'd1,  4'd9,  5'd10, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic epush(input logic [31:0] d);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = d;
    @(posedge clk); #1 eng_rx_push = 0;
  endtask

  task automatic epop();
    @(negedge clk); eng_tx_pop = 1;
    @(posedge clk); #1 eng_tx_pop = 0;
  endtask

  task automatic both_push(input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'd0; reg_wdata = d; eng_rx_push = 1; eng_rx_data = d;
    @(posedge clk); #1 reg_wr = 0; eng_rx_push = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state
    rd(4'd3, v); chk("R6 R12 reset status", v, 32'h4080);
    rd(4'd6, v); chk("R1 reset levels", v, 0);
    chk("R9 R10 R11 R12 reset irqs", {irq_idle, irq_err, irq_end, irq_rx, irq_tx}, 0);
    chk("R2 reset valid", eng_tx_valid, 0);

    // trigger table
    for (int i = 0; i < 8; i++) begin
      logic [14:0] e;
      e = VEC[i];
      wr(4'd5, 1);
      wr(4'd2, {20'd0, e[14:11], 4'd0, e[10:7]});
      for (int k = 0; k < int'(e[6:2]); k++) both_push(32'h100 + k);
      rd(4'd2, v); chk("R4 thresh readback", v, {20'd0, e[14:11], 4'd0, e[10:7]});
      rd(4'd3, v);
      chk("R6 tx-empty bit7", v[7], e[1]);
      chk("R5 rx-full bit15", v[15], e[0]);
      rd(4'd6, v); chk("R1 levels", v, {11'd0, e[6:2], 11'd0, e[6:2]});
    end
    wr(4'd5, 1);
    wr(4'd2, 0);

    // R2 order and run gating
    wr(4'd0, 32'hA1); wr(4'd0, 32'hB2); wr(4'd0, 32'hC3);
    chk("R2 valid needs run", eng_tx_valid, 0);
    wr(4'd1, 32'h1);
    chk("R2 valid", eng_tx_valid, 1);
    chk("R2 first word", eng_tx_data, 32'hA1);
    epop(); chk("R2 second word", eng_tx_data, 32'hB2);
    epop(); chk("R2 third word", eng_tx_data, 32'hC3);
    epop(); chk("R2 drained", eng_tx_valid, 0);

    // R3 order and underflow
    wr(4'd1, 32'h0);
    epush(32'h11); epush(32'h22);
    rd(4'd0, v); chk("R3 pop first", v, 32'h11);
    rd(4'd0, v); chk("R3 pop second", v, 32'h22);
    rd(4'd0, v); chk("R3 empty read zero", v, 0);
    rd(4'd3, v); chk("R3 underflow bit8", v[8], 1);
    wr(4'd1, 32'h0004_0000);
    chk("R12 err level", irq_err, 1);
    wr(4'd4, 32'hFD80);
    rd(4'd3, v); chk("R7 clear underflow", v[8], 0);
    chk("R12 err drops", irq_err, 0);

    // R1 / R13 overflow, R7 partial clear
    wr(4'd1, 32'h0);
    for (int k = 0; k < 17; k++) both_push(32'h200 + k);
    rd(4'd6, v); chk("R1 R13 saturate at 16", v, {11'd0, 5'd16, 11'd0, 5'd16});
    rd(4'd3, v); chk("R1 tx overflow bit11", v[11], 1);
    chk("R13 rx overflow bit10", v[10], 1);
    wr(4'd4, 32'h0400);
    rd(4'd3, v); chk("R7 partial clears bit10", v[10], 0);
    chk("R7 partial keeps bit11", v[11], 1);
    wr(4'd4, 32'hFD80);
    rd(4'd3, v); chk("R7 full clear sticky", v & 32'h1D00, 0);
    chk("R7 level rx-full kept", v[15], 1);
    rd(4'd0, v); chk("R13 oldest kept", v, 32'h200);

    // R8 flush
    wr(4'd5, 1);
    rd(4'd6, v); chk("R8 flush empties", v, 0);

    // R9 gating then pulse
    wr(4'd2, 32'h1);
    epush(1); @(negedge clk); chk("R9 no pulse below trig", irq_rx, 0);
    epush(2); @(negedge clk); chk("R9 gated by bit17", irq_rx, 0);
    wr(4'd5, 1);
    wr(4'd1, 32'h0002_0000);
    epush(1); @(negedge clk); chk("R9 no pulse below trig", irq_rx, 0);
    epush(2); @(negedge clk); chk("R9 pulse", irq_rx, 1);
    @(negedge clk); chk("R9 pulse ends", irq_rx, 0);
    wr(4'd5, 1);

    // R10 transmit pulse
    wr(4'd1, 32'h0001_0001);
    wr(4'd2, 32'h100);
    wr(4'd0, 1); wr(4'd0, 2); wr(4'd0, 3);
    @(negedge clk); chk("R10 no pulse above trig", irq_tx, 0);
    epop(); @(negedge clk); chk("R10 no pulse at level 2", irq_tx, 0);
    epop(); @(negedge clk); chk("R10 pulse at trig", irq_tx, 1);
    @(negedge clk); chk("R10 pulse ends", irq_tx, 0);
    wr(4'd5, 1);

    // R11 end pulse
    wr(4'd1, 32'h0010_0000);
    @(negedge clk); eng_done = 1; @(posedge clk); #1 eng_done = 0;
    @(negedge clk); chk("R11 end pulse", irq_end, 1);
    @(negedge clk); chk("R11 end pulse ends", irq_end, 0);
    rd(4'd3, v); chk("R11 end flag bit12", v[12], 1);
    wr(4'd4, 32'hFD80);
    wr(4'd0, 7);
    @(negedge clk); eng_done = 1; @(posedge clk); #1 eng_done = 0;
    @(negedge clk); chk("R11 no end with words", irq_end, 0);
    rd(4'd3, v); chk("R11 no flag with words", v[12], 0);
    wr(4'd5, 1);

    // R12 idle level
    wr(4'd1, 32'h0008_0000);
    @(negedge clk); chk("R12 idle high", irq_idle, 1);
    eng_busy = 1; #2 chk("R12 idle low when busy", irq_idle, 0);
    rd(4'd3, v); chk("R12 idle status bit14", v[14], 0);
    eng_busy = 0;
    wr(4'd0, 9);
    @(negedge clk); chk("R12 idle low with words", irq_idle, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule